// File: doc/BRIEF.md
# Frame-Based SPI Master with Word FIFOs

This block is an SPI master that moves one frame at a time. A frame is a programmed number of words, each 8 to 32 bits long. Words to send are queued in a transmit FIFO and received words are pushed into a receive FIFO. FIFO entries are 32 bits wide and hold the word left-justified, so software shifts a word up by (32 - bits) on write and down by the same amount on read.

A small register interface sets the frame shape, the clock idle level, the transmit and receive clock edges, the bit order and a transmit tri-state option. A set of enable bits starts the frame. End-of-frame flags in a status register can raise an interrupt. The serial clock advances only on an external divider tick input. Chip select is driven outside the block.

Top module: `frame_spi_master`

## Requirements
- R1: The frame register (address 2) holds bits-1 in bits 28:24 and words-1 in bits 23:16. Legal word lengths are 8 to 32. A frame shifts exactly bits x words data bits, with one sampling edge for each bit.
- R2: Bit 24 of the format register (address 1) selects LSB-first shifting when set and MSB-first shifting when clear. The same order applies to transmit and receive.
- R3: Control bit 30 sets the serial clock idle level (CPOL). Bit 27 selects the transmit edge and bit 26 the receive edge (1 = falling, 0 = rising). When software programs bit 27 = CPOL ? CPHA : !CPHA and bit 26 as its complement, the data follows standard SPI modes 0 to 3.
- R4: A write to address 5 pushes a transmit entry and a read of address 6 pops a receive entry. Both entries hold the word in the top bits, and the receive entry has zeros below the word.
- R5: A frame runs only while control bits 15 (clock enable), 9 (transmit enable) and 14 (frame start) are all set. Control bit 8 (receive enable) gates the pushes into the receive FIFO and the receive end-of-frame flag.
- R6: The status register (address 3) sets bit 23 (transmit end) and, with receive enabled, bit 7 (receive end) once the clock is back at its idle level. Writing 1 to a status bit clears it. The irq output is high while a status bit at 23 or 7 is set together with the same bit of the interrupt enable register (address 4).
- R7: After a frame ends while frame start stays set, the block stays idle with the clock parked at the idle level. Clearing frame start and setting it again runs a new frame.
- R8: With frame register bit 0 set, the block sends zeros and does not pop the transmit FIFO.
- R9: A read of an empty receive FIFO returns 0 and leaves it empty. A write to a full transmit FIFO is dropped and sets status bit 0, which is sticky and cleared by writing 1.
- R10: The control register (address 0) reads back bits 30, 28, 27, 26, 23, 15, 14, 9 and 8 as written. All its other bits read 0.
- R11: The serial clock changes only in a cycle that follows a sclkTick pulse. Each tick moves it by one half period.
- R12: With control bit 23 set, mosiOe is low whenever no frame is running. mosiOe is high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the receive FIFO at address 6) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| sclkTick | input | 1 | Divider enable; one pulse per serial half period |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosiOe | output | 1 | Output enable for mosi |
| irq | output | 1 | End-of-frame interrupt |

## Verification
The bench builds the block with a FIFO depth of 4. At that depth, filling and overfilling both FIFOs takes only a handful of writes, so the overflow flag and the dropped entry can be reached quickly. The bench loops mosi back to miso. It sweeps all four clock modes, both bit orders, word lengths of 8, 13 and 32 and frames of 1 and 4 words. For each frame it captures the serial bit stream at the slave's sampling edge and compares it bit by bit with the order it computes, and it checks the left-justified words that come back.

// File: rtl/frame_spi_pkg.sv
package frame_spi_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_FMT   = 3'd1;
  localparam logic [2:0] A_FRAME = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_IEN   = 3'd4;
  localparam logic [2:0] A_TXD   = 3'd5;
  localparam logic [2:0] A_RXD   = 3'd6;

  localparam int B_IDLE   = 30;
  localparam int B_TXEDGE = 27;
  localparam int B_RXEDGE = 26;
  localparam int B_TXTRI  = 23;
  localparam int B_CLKEN  = 15;
  localparam int B_FSTART = 14;
  localparam int B_TXEN   = 9;
  localparam int B_RXEN   = 8;
  localparam int B_LSB    = 24;
  localparam int B_NOTX   = 0;
  localparam int B_TXEOF  = 23;
  localparam int B_RXEOF  = 7;
  localparam int B_OVF    = 0;

  localparam logic [31:0] CTRL_MASK = 32'h5C80_C300;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
  } dpStrobe_t;

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction
endpackage

// File: rtl/frame_spi_fifo.sv
module frame_spi_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic doWr, doRd;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doWr   = wrEn & ~full;
  assign doRd   = rdEn & ~empty;
  assign rdData = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doWr) - CW'(doRd);
    end
  end

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full && !rdEn) |=> $stable(count));
  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && empty && !wrEn) |=> empty);
endmodule

// File: rtl/frame_spi_dp.sv
module frame_spi_dp
  import frame_spi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strobe,
  input  logic        lsbFirst,
  input  logic        noTx,
  input  logic [4:0]  bitsM1,
  input  logic [31:0] txHead,
  input  logic        txEmpty,
  input  logic        miso,
  output logic        mosi,
  output logic [31:0] rxWord
);
  logic [31:0] txSh, rxSh, rxNext, rxMasked, loadVal;
  logic [5:0]  padBits;

  // number of unused low bits in a left-justified entry: 32 - bits
  assign padBits  = 6'd31 - {1'b0, bitsM1};
  assign loadVal  = (noTx || txEmpty) ? '0 :
                    (lsbFirst ? (rev32(txHead) << padBits) : txHead);
  assign rxNext   = {rxSh[30:0], miso};
  assign rxMasked = rxNext & (32'hFFFF_FFFF >> padBits);
  assign rxWord   = lsbFirst ? rev32(rxMasked) : (rxMasked << padBits);
  assign mosi     = txSh[31];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
      rxSh <= '0;
    end else begin
      if (strobe.loadTx)       txSh <= loadVal;
      else if (strobe.shiftTx) txSh <= {txSh[30:0], 1'b0};
      if (strobe.sampleRx)     rxSh <= rxNext;
    end
  end
endmodule

// File: rtl/frame_spi_ctrl.sv
module frame_spi_ctrl
  import frame_spi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        sclkTick,
  input  logic        txFull,
  input  logic        txEmpty,
  input  logic [31:0] rxHead,
  output logic        txPush,
  output logic        txPop,
  output logic        rxPush,
  output logic        rxPop,
  output dpStrobe_t   strobe,
  output logic        lsbFirst,
  output logic        noTx,
  output logic [4:0]  bitsM1,
  output logic        sclk,
  output logic        mosiOe,
  output logic        irq
);
  logic [31:0] ctrlReg;
  logic [7:0]  wordsM1;
  logic        ienTx, ienRx, stTx, stRx, stOvf;
  logic        started, frameDone, draining, armed, needLoad, sclkReg;
  logic [4:0]  bitCnt;
  logic [7:0]  wordCnt;
  logic        idleLvl, fStart, active, startNow, tickNow, nextSclk, edgeFall;
  logic        isRxEdge, isTxEdge, wordEnd, frameEnd, doLoad, doShift, finishNow, wrStat;

  assign idleLvl  = ctrlReg[B_IDLE];
  assign fStart   = ctrlReg[B_FSTART];
  assign active   = started & ~frameDone & ctrlReg[B_CLKEN] & ctrlReg[B_TXEN];
  assign startNow = fStart & ctrlReg[B_CLKEN] & ctrlReg[B_TXEN] & ~started & ~frameDone;
  assign tickNow  = active & sclkTick;
  assign nextSclk = ~sclkReg;
  assign edgeFall = sclkReg;
  assign isRxEdge = tickNow & ~draining & (edgeFall == ctrlReg[B_RXEDGE]);
  assign isTxEdge = tickNow & ~draining & (edgeFall == ctrlReg[B_TXEDGE]) & ~isRxEdge;
  assign wordEnd  = isRxEdge & (bitCnt == bitsM1);
  assign frameEnd = wordEnd & (wordCnt == wordsM1);
  assign doLoad   = startNow | (isTxEdge & needLoad);
  assign doShift  = isTxEdge & ~needLoad & armed;
  assign finishNow = (frameEnd & (nextSclk == idleLvl)) | (tickNow & draining);

  assign strobe.loadTx   = doLoad;
  assign strobe.shiftTx  = doShift;
  assign strobe.sampleRx = isRxEdge;
  assign txPop  = doLoad & ~noTx;
  assign rxPush = wordEnd & ctrlReg[B_RXEN];
  assign txPush = regWrEn & (regAddr == A_TXD);
  assign rxPop  = regRdEn & (regAddr == A_RXD);
  assign wrStat = regWrEn & (regAddr == A_STAT);

  assign sclk   = sclkReg;
  assign mosiOe = ~ctrlReg[B_TXTRI] | (started & ~frameDone);
  assign irq    = (stTx & ienTx) | (stRx & ienRx);

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      lsbFirst <= 1'b0;
      bitsM1   <= '0;
      wordsM1  <= '0;
      noTx     <= 1'b0;
      ienTx    <= 1'b0;
      ienRx    <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        A_CTRL:  ctrlReg <= regWrData & CTRL_MASK;
        A_FMT:   lsbFirst <= regWrData[B_LSB];
        A_FRAME: begin
          bitsM1  <= regWrData[28:24];
          wordsM1 <= regWrData[23:16];
          noTx    <= regWrData[B_NOTX];
        end
        A_IEN: begin
          ienTx <= regWrData[B_TXEOF];
          ienRx <= regWrData[B_RXEOF];
        end
        default: ;
      endcase
    end
  end

  // status flags: set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stTx  <= 1'b0;
      stRx  <= 1'b0;
      stOvf <= 1'b0;
    end else begin
      stTx  <= (stTx & ~(wrStat & regWrData[B_TXEOF])) | finishNow;
      stRx  <= (stRx & ~(wrStat & regWrData[B_RXEOF])) | (finishNow & ctrlReg[B_RXEN]);
      stOvf <= (stOvf & ~(wrStat & regWrData[B_OVF])) | (txPush & txFull);
    end
  end

  // frame sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started   <= 1'b0;
      frameDone <= 1'b0;
      draining  <= 1'b0;
      armed     <= 1'b0;
      needLoad  <= 1'b0;
      bitCnt    <= '0;
      wordCnt   <= '0;
      sclkReg   <= 1'b0;
    end else if (!fStart || !started) begin
      frameDone <= fStart & frameDone;
      draining  <= 1'b0;
      armed     <= 1'b0;
      needLoad  <= 1'b0;
      bitCnt    <= '0;
      wordCnt   <= '0;
      sclkReg   <= idleLvl;
      started   <= startNow;
    end else begin
      if (tickNow) sclkReg <= nextSclk;
      if (isRxEdge) begin
        if (wordEnd) begin
          bitCnt <= '0;
          armed  <= 1'b0;
          if (!frameEnd) begin
            wordCnt  <= wordCnt + 1'b1;
            needLoad <= 1'b1;
          end
        end else begin
          bitCnt <= bitCnt + 1'b1;
          armed  <= 1'b1;
        end
      end
      if (doLoad) begin
        needLoad <= 1'b0;
        armed    <= 1'b0;
      end
      if (doShift) armed <= 1'b0;
      if (frameEnd && (nextSclk != idleLvl)) draining <= 1'b1;
      if (finishNow) begin
        frameDone <= 1'b1;
        draining  <= 1'b0;
      end
    end
  end

  always_comb begin
    case (regAddr)
      A_CTRL:  regRdData = ctrlReg;
      A_FMT:   regRdData = {7'b0, lsbFirst, 24'b0};
      A_FRAME: regRdData = {3'b0, bitsM1, wordsM1, 15'b0, noTx};
      A_STAT:  regRdData = {8'b0, stTx, 15'b0, stRx, 6'b0, stOvf};
      A_IEN:   regRdData = {8'b0, ienTx, 15'b0, ienRx, 7'b0};
      A_RXD:   regRdData = rxHead;
      default: regRdData = '0;
    endcase
  end

  p_idle_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDone) |-> (sclkReg == idleLvl));
  p_tick_only_r11: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(started) && !$past(sclkTick)) |-> $stable(sclkReg));
  p_eof_w1c_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && regWrData[B_TXEOF] && !finishNow) |=> !stTx);
  p_word_count_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDone) |-> (wordCnt == wordsM1));
endmodule

// File: rtl/frame_spi_master.sv
module frame_spi_master
  import frame_spi_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        sclkTick,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        mosiOe,
  output logic        irq
);
  dpStrobe_t   strobe;
  logic        txPush, txPop, rxPush, rxPop;
  logic        txFull, txEmpty, rxFull, rxEmpty;
  logic        lsbFirst, noTx;
  logic [4:0]  bitsM1;
  logic [31:0] txHead, rxHead, rxWord;

  frame_spi_ctrl u_ctrl (
    .clk, .rstN, .regWrEn, .regRdEn, .regAddr, .regWrData, .regRdData,
    .sclkTick, .txFull, .txEmpty, .rxHead,
    .txPush, .txPop, .rxPush, .rxPop, .strobe,
    .lsbFirst, .noTx, .bitsM1, .sclk, .mosiOe, .irq
  );

  frame_spi_dp u_dp (
    .clk, .rstN, .strobe, .lsbFirst, .noTx, .bitsM1,
    .txHead, .txEmpty, .miso, .mosi, .rxWord
  );

  frame_spi_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk, .rstN, .wrEn(txPush), .wrData(regWrData), .rdEn(txPop),
    .rdData(txHead), .empty(txEmpty), .full(txFull)
  );

  frame_spi_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk, .rstN, .wrEn(rxPush), .wrData(rxWord), .rdEn(rxPop),
    .rdData(rxHead), .empty(rxEmpty), .full(rxFull)
  );

  p_rx_no_over_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull) |=> rxFull);
  p_pop_has_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && noTx) |-> 1'b0);
endmodule

// File: tb/frame_spi_master_tb.sv
module frame_spi_master_tb;
  localparam logic [2:0] A_CTRL = 0, A_FMT = 1, A_FRAME = 2, A_STAT = 3, A_IEN = 4, A_TXD = 5, A_RXD = 6;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [2:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic sclkTick = 0, sclk, mosi, mosiOe, irq;
  logic tickHold = 0;

  int checks = 0, fails = 0;
  logic capBits [0:255];
  int capN = 0, capCpol = 0, capCpha = 0;
  logic prevSclk = 0;
  logic [31:0] txVal [0:7];
  logic [31:0] expVal [0:7];
  logic [31:0] ctrlVal = 0;
  int seed = 0, curBits = 8, curWords = 1, curLsb = 0;

  frame_spi_master #(.FIFO_DEPTH(4)) u_dut (
    .clk, .rstN, .regWrEn, .regRdEn, .regAddr, .regWrData, .regRdData,
    .sclkTick, .miso(mosi), .sclk, .mosi, .mosiOe, .irq
  );

  always #10 clk = ~clk;

  initial begin : tickGen
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      sclkTick = !tickHold && (cnt % 3 == 0);
    end
  end

  initial begin : slaveCapture
    forever begin
      @(negedge clk);
      if (sclk !== prevSclk) begin
        if ((sclk != capCpol[0]) == (capCpha == 0)) begin
          if (capN < 256) capBits[capN] = mosi;
          capN++;
        end
        prevSclk = sclk;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=hang expected=finish");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
    regRdEn = 1;
    @(negedge clk);
    regRdEn = 0;
  endtask

  function automatic logic [31:0] wmask(input int bits);
    return (bits == 32) ? 32'hFFFF_FFFF : ((32'h1 << bits) - 1);
  endfunction

  task automatic setup(input int cpol, input int cpha, input int lsb, input int bits,
                       input int words, input bit noTx, input logic [31:0] ienVal, input int pushN);
    int tedge;
    tedge = (cpol != 0) ? cpha : ((cpha == 0) ? 1 : 0);
    curBits = bits; curWords = words; curLsb = lsb;
    capCpol = cpol; capCpha = cpha;
    ctrlVal = (32'(cpol) << 30) | (32'(cpol) << 28) | (32'(tedge) << 27) | (32'(tedge == 0) << 26);
    wr(A_CTRL, ctrlVal);
    wr(A_FMT, 32'(lsb) << 24);
    wr(A_FRAME, (32'(bits - 1) << 24) | (32'(words - 1) << 16) | 32'(noTx));
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_IEN, ienVal);
    for (int i = 0; i < pushN; i++) begin
      seed++;
      txVal[i] = ((32'h9E37_79B9 * 32'(seed * 7 + i + 1)) ^ (32'(seed) << 9)) & wmask(bits);
      expVal[i] = txVal[i];
      wr(A_TXD, txVal[i] << (32 - bits));
    end
    repeat (2) @(negedge clk);
    capN = 0;
  endtask

  task automatic startFrame(input bit rxOn);
    ctrlVal |= 32'h1 << 15; wr(A_CTRL, ctrlVal);
    if (rxOn) begin ctrlVal |= 32'h1 << 8; wr(A_CTRL, ctrlVal); end
    ctrlVal |= 32'h1 << 9;  wr(A_CTRL, ctrlVal);
    ctrlVal |= 32'h1 << 14; wr(A_CTRL, ctrlVal);
  endtask

  task automatic waitEnd();
    logic [31:0] s;
    s = 0;
    for (int g = 0; g < 20000 && !s[23]; g++) rd(A_STAT, s);
  endtask

  task automatic stopFrame();
    ctrlVal &= ~(32'h1 << 14); wr(A_CTRL, ctrlVal);
    ctrlVal &= ~(32'h1 << 9);  wr(A_CTRL, ctrlVal);
    ctrlVal &= ~(32'h1 << 8);  wr(A_CTRL, ctrlVal);
    ctrlVal &= ~(32'h1 << 15); wr(A_CTRL, ctrlVal);
  endtask

  task automatic checkStream(input string tag);
    int bad;
    bad = 0;
    for (int w = 0; w < curWords; w++)
      for (int k = 0; k < curBits; k++) begin
        int idx;
        logic e;
        idx = w * curBits + k;
        e = (curLsb != 0) ? expVal[w][k] : expVal[w][curBits - 1 - k];
        if (idx < 256 && capBits[idx] !== e) bad++;
      end
    chk({tag, " bit count"}, 32'(capN), 32'(curWords * curBits));
    chk({tag, " bit order mismatches"}, 32'(bad), 0);
  endtask

  initial begin : main
    logic [31:0] d;
    int bitSet [3];
    bitSet = '{8, 13, 32};
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);

    // reset state
    rd(A_CTRL, d); chk("R10 reset ctrl", d, 0);
    rd(A_STAT, d); chk("R6 reset status", d, 0);
    chk("R6 reset irq", 32'(irq), 0);
    chk("R3 reset sclk", 32'(sclk), 0);
    chk("R12 reset mosiOe", 32'(mosiOe), 1);
    rd(A_RXD, d); chk("R9 empty rx read", d, 0);
    rd(A_RXD, d); chk("R9 empty rx read again", d, 0);

    // control readback, frame start kept clear
    wr(A_CTRL, 32'hFFFF_BFFF);
    rd(A_CTRL, d); chk("R10 ctrl readback mask", d, 32'h5C80_8300);
    chk("R12 mosiOe low when idle and tri-state", 32'(mosiOe), 0);
    wr(A_CTRL, 32'h0);
    chk("R12 mosiOe high without tri-state", 32'(mosiOe), 1);

    // sweep: modes x bit order x word length x word count
    for (int m = 0; m < 4; m++)
      for (int lsb = 0; lsb < 2; lsb++)
        for (int bi = 0; bi < 3; bi++)
          for (int wc = 1; wc <= 4; wc += 3) begin
            setup(m / 2, m % 2, lsb, bitSet[bi], wc, 0, 32'h0080_0080, wc);
            startFrame(1);
            waitEnd();
            checkStream("R1 R2 R3");
            for (int w = 0; w < wc; w++) begin
              rd(A_RXD, d);
              chk("R4 rx left-justified word", d, txVal[w] << (32 - bitSet[bi]));
            end
            rd(A_STAT, d); chk("R6 status after frame", d, 32'h0080_0080);
            chk("R6 irq raised", 32'(irq), 1);
            chk("R7 clock parked at idle", 32'(sclk), 32'(m / 2));
            stopFrame();
            wr(A_STAT, 32'hFFFF_FFFF);
            rd(A_STAT, d); chk("R6 status cleared by W1C", d, 0);
            chk("R6 irq low after clear", 32'(irq), 0);
          end

    // R5: no transmit enable, nothing runs
    setup(0, 0, 0, 8, 1, 0, 32'h0, 1);
    wr(A_CTRL, ctrlVal | (32'h1 << 15) | (32'h1 << 14));
    repeat (60) @(negedge clk);
    rd(A_STAT, d); chk("R5 no frame without txEn", d, 0);
    chk("R5 no clock edges without txEn", 32'(capN), 0);
    wr(A_CTRL, ctrlVal);

    // R11: holding the tick freezes the clock; R5 rx disabled
    tickHold = 1;
    startFrame(0);
    repeat (40) @(negedge clk);
    chk("R11 no clock edge without tick", 32'(capN), 0);
    chk("R11 sclk at idle without tick", 32'(sclk), 0);
    tickHold = 0;
    waitEnd();
    checkStream("R11 after release");
    rd(A_STAT, d); chk("R5 rxEn off gives tx end only", d, 32'h0080_0000);
    chk("R6 irq masked with enables clear", 32'(irq), 0);
    rd(A_RXD, d); chk("R5 no rx push with rxEn off", d, 0);
    wr(A_IEN, 32'h0080_0000);
    chk("R6 irq on tx end enable", 32'(irq), 1);
    wr(A_STAT, 32'h0080_0000);
    chk("R6 irq low after W1C", 32'(irq), 0);

    // R7: frame start held after end, then re-armed
    stopFrame();
    setup(1, 1, 0, 8, 1, 0, 32'h0, 2);
    startFrame(1);
    waitEnd();
    repeat (60) @(negedge clk);
    chk("R7 idle while start held", 32'(capN), 8);
    chk("R7 sclk parked high", 32'(sclk), 1);
    rd(A_RXD, d); chk("R7 first frame word", d, txVal[0] << 24);
    wr(A_STAT, 32'hFFFF_FFFF);
    ctrlVal &= ~(32'h1 << 14); wr(A_CTRL, ctrlVal);
    capN = 0; expVal[0] = txVal[1];
    ctrlVal |= 32'h1 << 14; wr(A_CTRL, ctrlVal);
    waitEnd();
    checkStream("R7 rerun");
    rd(A_RXD, d); chk("R7 rerun word", d, txVal[1] << 24);
    stopFrame();

    // R8: no transmit data, FIFO untouched
    setup(0, 0, 0, 16, 1, 1, 32'h0, 1);
    expVal[0] = 0;
    startFrame(1);
    waitEnd();
    checkStream("R8 zero fill");
    rd(A_RXD, d); chk("R8 zero word received", d, 0);
    stopFrame();
    wr(A_FRAME, (32'(15) << 24));
    wr(A_STAT, 32'hFFFF_FFFF);
    capN = 0; expVal[0] = txVal[0];
    startFrame(1);
    waitEnd();
    checkStream("R8 queued word kept");
    rd(A_RXD, d); chk("R8 queued word sent later", d, txVal[0] << 16);
    stopFrame();

    // R9: overflow of a 4-entry transmit FIFO
    setup(0, 0, 1, 8, 4, 0, 32'h0, 5);
    rd(A_STAT, d); chk("R9 overflow flag set", d, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R9 overflow flag cleared", d, 0);
    startFrame(1);
    waitEnd();
    for (int w = 0; w < 4; w++) begin
      rd(A_RXD, d); chk("R9 first four kept", d, txVal[w] << 24);
    end
    stopFrame();
    wr(A_FRAME, (32'(7) << 24));
    wr(A_STAT, 32'hFFFF_FFFF);
    startFrame(1);
    waitEnd();
    rd(A_RXD, d); chk("R9 fifth word dropped", d, 0);
    rd(A_RXD, d); chk("R9 rx empty after drain", d, 0);
    stopFrame();

    summary();
    $finish;
  end
endmodule